// File: doc/BRIEF.md
# Bus Master Retry Sequencer

This block is the bus-master side of a single-transfer external bus. An internal requester hands it one transfer at a time: address, attribute bits, direction and write data. The sequencer wins the bus, drives one address clock, then waits for the cycle to end. A cycle can end in three ways. An acknowledge completes it, and read data is returned to the requester. An error also completes it, and the requester sees an error status. A retry abandons it: the sequencer frees the bus, takes part in arbitration again, and reissues the same transfer from its own holding register.

The arbiter mode is chosen with a pin. With the internal arbiter, the sequencer itself grants the bus to one other master. Right after a retry it offers that master the bus for one clock. With an external arbiter, the sequencer raises a request and waits for a grant. After a retry it drops the request together with busy, then raises the request again one clock later. The mode pin is expected to change only while the sequencer is idle.

Top module: `bus_retry_master`

## Requirements
- R1: `req_ready_o` is high only while no transfer is outstanding. A request accepted there is captured, and `req_ready_o` stays low until its completion is reported.
- R2: With `arb_int_i`=0, `bus_br_o` is high from the clock after acceptance until the termination clock. A transfer starts only after a clock in which `bus_bg_i`=1 and `bus_bb_i`=0.
- R3: With `arb_int_i`=1, `bus_br_o` stays low. While the sequencer waits and `bus_br_i`=1, `bus_bg_o` is high and no transfer starts. A transfer starts after a clock in which `bus_br_i`=0 and `bus_bb_i`=0.
- R4: `bus_start_o` pulses for exactly the first address clock. `bus_bb_o` is high from that clock through the termination clock, and is low otherwise.
- R5: An acknowledge ends the cycle. In the next clock `rsp_valid_o`=1 with `rsp_status_o`=2'b00, and for a read `rsp_rdata_o` holds the `bus_rdata_i` value from the termination clock.
- R6: An error ends the cycle without retrying. In the next clock `rsp_valid_o`=1 with `rsp_status_o`=2'b01.
- R7: In the clock after a retry, `bus_bb_o`=0 and no completion is reported.
- R8: With `arb_int_i`=1, `bus_bg_o`=1 in the clock after a retry. In the clock after that, normal arbitration applies again.
- R9: With `arb_int_i`=0, `bus_br_o`=0 in the clock after a retry, and `bus_br_o`=1 again one clock later.
- R10: Every reissue drives the same `bus_addr_o`, `bus_attr_o`, `bus_write_o` and `bus_wdata_o` as the first attempt, whatever the requester inputs do meanwhile.
- R11: When terminations arrive in the same clock, error wins over retry, and retry wins over acknowledge. Terminations seen while `bus_bb_o`=0 are ignored.
- R12: Each accepted request gets exactly one one-clock `rsp_valid_o` pulse, and no pulse appears otherwise.
- R13: After a retry, if another master holds the bus (`bus_bb_i`=1), the sequencer does not start until the bus is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_int_i | input | 1 | 1 = internal arbiter mode, 0 = external arbiter mode |
| req_valid_i | input | 1 | Requester offers a transfer |
| req_ready_o | output | 1 | Sequencer can accept a transfer |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Transfer address |
| req_attr_i | input | TW | Address attribute bits |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Completion pulse |
| rsp_status_o | output | 2 | 00 = OK, 01 = error |
| rsp_rdata_o | output | DW | Read data of the completed transfer |
| bus_br_o | output | 1 | Bus request to an external arbiter |
| bus_bg_i | input | 1 | Bus grant from an external arbiter |
| bus_br_i | input | 1 | Request from another master (internal arbiter mode) |
| bus_bg_o | output | 1 | Grant to another master (internal arbiter mode) |
| bus_bb_i | input | 1 | Another master holds the bus |
| bus_bb_o | output | 1 | Sequencer holds the bus |
| bus_start_o | output | 1 | First address clock strobe |
| bus_addr_o | output | AW | Bus address |
| bus_attr_o | output | TW | Bus address attributes |
| bus_write_o | output | 1 | Bus direction |
| bus_wdata_o | output | DW | Bus write data |
| bus_rdata_i | input | DW | Bus read data |
| bus_ack_i | input | 1 | Normal termination |
| bus_err_i | input | 1 | Error termination |
| bus_rty_i | input | 1 | Retry termination |

## Verification
The hardest case to reach is a replay that must wait behind another master. That needs a retry first, then a competing master in the arbitration clock that follows, and it must hold for both arbiter modes. The stimulus drives a chain of retries per transfer and, at random, steals the bus after a retry: another master requests or holds busy, or the external grant is withheld. Meanwhile the requester inputs are scrambled, so a replay taken from the live inputs instead of the holding register shows up. Some termination clocks combine retry, error and acknowledge to test the priority order.

// File: rtl/bmrs_pkg.sv
package bmrs_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE = 3'd0,
    SEQ_ARB  = 3'd1,
    SEQ_ADDR = 3'd2,
    SEQ_DATA = 3'd3,
    SEQ_REL  = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    TERM_NONE = 2'd0,
    TERM_ACK  = 2'd1,
    TERM_ERR  = 2'd2,
    TERM_RTY  = 2'd3
  } term_e;

  localparam int unsigned RSP_W = 2;
  localparam logic [RSP_W-1:0] RSP_OK  = 2'b00;
  localparam logic [RSP_W-1:0] RSP_ERR = 2'b01;
endpackage

// File: rtl/bmrs_term_decode.sv
module bmrs_term_decode
  import bmrs_pkg::*;
(
  input  logic  active_i,
  input  logic  ack_i,
  input  logic  err_i,
  input  logic  rty_i,
  output term_e term_o
);
  // Error outranks retry, retry outranks acknowledge (R11).
  always_comb begin
    term_o = TERM_NONE;
    if (active_i) begin
      if (err_i)      term_o = TERM_ERR;
      else if (rty_i) term_o = TERM_RTY;
      else if (ack_i) term_o = TERM_ACK;
    end
  end
endmodule

// File: rtl/bmrs_xfer_hold.sv
module bmrs_xfer_hold #(
  parameter int unsigned AW = 32,
  parameter int unsigned TW = 4,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [TW-1:0] attr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          write_o,
  output logic [AW-1:0] addr_o,
  output logic [TW-1:0] attr_o,
  output logic [DW-1:0] wdata_o
);
  logic          write_q;
  logic [AW-1:0] addr_q;
  logic [TW-1:0] attr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      attr_q  <= '0;
      wdata_q <= '0;
    end else if (load_i) begin
      write_q <= write_i;
      addr_q  <= addr_i;
      attr_q  <= attr_i;
      wdata_q <= wdata_i;
    end
  end

  assign write_o = write_q;
  assign addr_o  = addr_q;
  assign attr_o  = attr_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/bmrs_arb_if.sv
module bmrs_arb_if
  import bmrs_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       arb_int_i,
  input  logic       bg_i,
  input  logic       bb_i,
  input  logic       br_i,
  output logic       br_o,
  output logic       bg_o,
  output logic       win_o
);
  logic waiting;
  logic owning;

  always_comb begin
    waiting = (state_i == SEQ_ARB);
    owning  = (state_i == SEQ_ADDR) || (state_i == SEQ_DATA);
    br_o    = 1'b0;
    bg_o    = 1'b0;
    win_o   = 1'b0;
    if (arb_int_i) begin
      if (state_i == SEQ_REL) bg_o = 1'b1;
      else if ((state_i == SEQ_IDLE) || waiting) bg_o = br_i;
      win_o = waiting && !br_i && !bb_i;
    end else begin
      br_o  = waiting || owning;
      win_o = waiting && bg_i && !bb_i;
    end
  end
endmodule

// File: rtl/bmrs_seq_fsm.sv
module bmrs_seq_fsm
  import bmrs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid_i,
  input  logic       win_i,
  input  term_e      term_i,
  output seq_state_e state_o,
  output logic       load_o,
  output logic       busy_o,
  output logic       start_o,
  output logic       done_o,
  output logic       done_err_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (req_valid_i) state_d = SEQ_ARB;
      SEQ_ARB:  if (win_i) state_d = SEQ_ADDR;
      SEQ_ADDR, SEQ_DATA: begin
        unique case (term_i)
          TERM_ACK, TERM_ERR: state_d = SEQ_IDLE;
          TERM_RTY:           state_d = SEQ_REL;
          default:            state_d = SEQ_DATA;
        endcase
      end
      SEQ_REL:  state_d = SEQ_ARB;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_o    = state_q;
    load_o     = (state_q == SEQ_IDLE) && req_valid_i;
    busy_o     = (state_q == SEQ_ADDR) || (state_q == SEQ_DATA);
    start_o    = (state_q == SEQ_ADDR);
    done_o     = busy_o && ((term_i == TERM_ACK) || (term_i == TERM_ERR));
    done_err_o = busy_o && (term_i == TERM_ERR);
  end
endmodule

// File: rtl/bus_retry_master.sv
module bus_retry_master
  import bmrs_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned TW = 4,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arb_int_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [TW-1:0] req_attr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [1:0]    rsp_status_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          bus_br_o,
  input  logic          bus_bg_i,
  input  logic          bus_br_i,
  output logic          bus_bg_o,
  input  logic          bus_bb_i,
  output logic          bus_bb_o,
  output logic          bus_start_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [TW-1:0] bus_attr_o,
  output logic          bus_write_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i,
  input  logic          bus_err_i,
  input  logic          bus_rty_i
);
  seq_state_e state;
  term_e      term;
  logic       load, busy, start, done, done_err, win;

  logic             rsp_valid_q;
  logic [RSP_W-1:0] rsp_status_q;
  logic [DW-1:0]    rsp_rdata_q;

  bmrs_term_decode u_term (
    .active_i (busy),
    .ack_i    (bus_ack_i),
    .err_i    (bus_err_i),
    .rty_i    (bus_rty_i),
    .term_o   (term)
  );

  bmrs_arb_if u_arb (
    .state_i   (state),
    .arb_int_i (arb_int_i),
    .bg_i      (bus_bg_i),
    .bb_i      (bus_bb_i),
    .br_i      (bus_br_i),
    .br_o      (bus_br_o),
    .bg_o      (bus_bg_o),
    .win_o     (win)
  );

  bmrs_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .win_i       (win),
    .term_i      (term),
    .state_o     (state),
    .load_o      (load),
    .busy_o      (busy),
    .start_o     (start),
    .done_o      (done),
    .done_err_o  (done_err)
  );

  bmrs_xfer_hold #(.AW(AW), .TW(TW), .DW(DW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .write_i (req_write_i),
    .addr_i  (req_addr_i),
    .attr_i  (req_attr_i),
    .wdata_i (req_wdata_i),
    .write_o (bus_write_o),
    .addr_o  (bus_addr_o),
    .attr_o  (bus_attr_o),
    .wdata_o (bus_wdata_o)
  );

  // Completion register: one pulse per finished transfer (R12).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= RSP_OK;
      rsp_rdata_q  <= '0;
    end else begin
      rsp_valid_q <= done;
      if (done) begin
        rsp_status_q <= done_err ? RSP_ERR : RSP_OK;
        rsp_rdata_q  <= bus_rdata_i;
      end
    end
  end

  assign req_ready_o  = (state == SEQ_IDLE);
  assign bus_bb_o     = busy;
  assign bus_start_o  = start;
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_status_o = rsp_status_q;
  assign rsp_rdata_o  = rsp_rdata_q;
endmodule

// File: rtl/bmrs_checker.sv
module bmrs_checker #(
  parameter int unsigned AW = 32,
  parameter int unsigned TW = 4,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arb_int_i,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic [1:0]    rsp_status_o,
  input logic          bus_br_o,
  input logic          bus_bg_o,
  input logic          bus_bb_i,
  input logic          bus_bb_o,
  input logic          bus_start_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [TW-1:0] bus_attr_o,
  input logic          bus_write_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          bus_ack_i,
  input logic          bus_err_i,
  input logic          bus_rty_i
);
  a_r4_start_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start_o |-> bus_bb_o);

  a_r4_busy_opens_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_bb_o) |-> bus_start_o);

  a_r5_ack_gives_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_bb_o && bus_ack_i && !bus_err_i && !bus_rty_i) |=> (rsp_valid_o && rsp_status_o == 2'b00));

  a_r6_err_gives_error: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_bb_o && bus_err_i) |=> (rsp_valid_o && rsp_status_o == 2'b01));

  a_r7_retry_frees_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_bb_o && bus_rty_i && !bus_err_i) |=> (!bus_bb_o && !rsp_valid_o));

  a_r8_grant_after_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_int_i && bus_bb_o && bus_rty_i && !bus_err_i) |=> bus_bg_o);

  a_r8_no_grant_while_owning: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_bg_o, bus_bb_o}));

  a_r9_request_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_int_i && bus_bb_o && bus_rty_i && !bus_err_i) |=> !bus_br_o);

  a_r9_request_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_int_i && $past(bus_bb_o && bus_rty_i && !bus_err_i, 2)) |-> bus_br_o);

  a_r10_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready_o && !$past(req_ready_o)) |->
      ($stable(bus_addr_o) && $stable(bus_attr_o) && $stable(bus_write_o) && $stable(bus_wdata_o)));

  a_r12_pulse_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(bus_bb_o));

  a_r13_start_needs_free_bus: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start_o |-> $past(!bus_bb_i));
endmodule

bind bus_retry_master bmrs_checker #(.AW(AW), .TW(TW), .DW(DW)) u_bmrs_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .arb_int_i    (arb_int_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_status_o (rsp_status_o),
  .bus_br_o     (bus_br_o),
  .bus_bg_o     (bus_bg_o),
  .bus_bb_i     (bus_bb_i),
  .bus_bb_o     (bus_bb_o),
  .bus_start_o  (bus_start_o),
  .bus_addr_o   (bus_addr_o),
  .bus_attr_o   (bus_attr_o),
  .bus_write_o  (bus_write_o),
  .bus_wdata_o  (bus_wdata_o),
  .bus_ack_i    (bus_ack_i),
  .bus_err_i    (bus_err_i),
  .bus_rty_i    (bus_rty_i)
);

// File: tb/bus_retry_master_tb.sv
`timescale 1ns/1ps
module bus_retry_master_tb;
  localparam int unsigned AW = 32;
  localparam int unsigned TW = 4;
  localparam int unsigned DW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic arb_int, req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [TW-1:0] req_attr;
  logic [DW-1:0] req_wdata;
  logic rsp_valid;
  logic [1:0] rsp_status;
  logic [DW-1:0] rsp_rdata;
  logic br_o, bg_i, br_i, bg_o, bb_i, bb_o, start;
  logic [AW-1:0] addr_o;
  logic [TW-1:0] attr_o;
  logic write_o;
  logic [DW-1:0] wdata_o, rdata_i;
  logic ack, err, rty;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  bus_retry_master #(.AW(AW), .TW(TW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .arb_int_i(arb_int),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_attr_i(req_attr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_rdata_o(rsp_rdata),
    .bus_br_o(br_o), .bus_bg_i(bg_i), .bus_br_i(br_i), .bus_bg_o(bg_o),
    .bus_bb_i(bb_i), .bus_bb_o(bb_o), .bus_start_o(start),
    .bus_addr_o(addr_o), .bus_attr_o(attr_o), .bus_write_o(write_o),
    .bus_wdata_o(wdata_o), .bus_rdata_i(rdata_i),
    .bus_ack_i(ack), .bus_err_i(err), .bus_rty_i(rty)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Bench model of termination priority: 0 none, 1 ack, 2 err, 3 retry.
  function automatic int resolve(input bit a, input bit e, input bit r);
    if (e) return 2;
    if (r) return 3;
    if (a) return 1;
    return 0;
  endfunction

  function automatic logic [1:0] exp_status(input int outcome);
    return (outcome == 2) ? 2'b01 : 2'b00;
  endfunction

  // Called at a falling edge with the sequencer idle; returns at a falling edge, idle.
  task automatic run_xfer(input bit mode_int, input bit wr, input logic [AW-1:0] a,
                          input logic [TW-1:0] t, input logic [DW-1:0] wd,
                          input logic [DW-1:0] rd, input int n_rty, input bit fin_err,
                          input bit steal, input bit combo);
    arb_int = mode_int;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_attr = t; req_wdata = wd;
    #1 chk("R1 ready while idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    req_write = ~wr; req_addr = $urandom; req_attr = $urandom; req_wdata = $urandom;
    chk("R1 ready low while outstanding", req_ready, 0);
    for (int att = 0; att <= n_rty; att++) begin
      int outcome;
      bit da, de, dr;
      if (!mode_int) chk("R2 request held in arbitration", br_o, 1);
      if (steal && att > 0) begin
        if (mode_int) begin
          br_i = 1'b1;
          #1 chk("R3 grant to other master", bg_o, 1);
          @(negedge clk);
          br_i = 1'b0; bb_i = 1'b1;
          chk("R3 no start while other requests", start, 0);
          @(negedge clk);
          chk("R13 no start while bus held", start, 0);
          bb_i = 1'b0;
        end else begin
          bg_i = 1'b0;
          @(negedge clk);
          chk("R2 no start without grant", start, 0);
          chk("R2 request kept", br_o, 1);
          bg_i = 1'b1;
        end
      end else if (!mode_int) begin
        bg_i = 1'b1;
      end
      @(negedge clk);
      bg_i = 1'b0;
      chk("R4 start strobe", start, 1);
      chk("R4 busy in address clock", bb_o, 1);
      chk("R10 address", addr_o, a);
      chk("R10 attributes", attr_o, t);
      chk("R10 direction", write_o, wr);
      chk("R10 write data", wdata_o, wd);
      if (mode_int) chk("R3 request unused", br_o, 0);
      for (int w = 0; w < int'($urandom_range(0, 2)); w++) begin
        @(negedge clk);
        chk("R4 busy while waiting", bb_o, 1);
        chk("R4 start only once", start, 0);
      end
      if (att < n_rty) begin
        dr = 1'b1; da = combo; de = 1'b0;
      end else begin
        de = fin_err; da = 1'b1; dr = fin_err && combo;
      end
      outcome = resolve(da, de, dr);
      ack = da; err = de; rty = dr; rdata_i = rd;
      @(negedge clk);
      ack = 1'b0; err = 1'b0; rty = 1'b0; rdata_i = $urandom;
      chk("R4 busy ends after termination", bb_o, 0);
      if (outcome == 3) begin
        chk("R7 no completion on retry", rsp_valid, 0);
        chk("R11 retry outranks ack", req_ready, 0);
        if (mode_int) chk("R8 grant offered after retry", bg_o, 1);
        else          chk("R9 request dropped after retry", br_o, 0);
        @(negedge clk);
        if (mode_int) chk("R8 arbitration resumes", bg_o, 0);
        else          chk("R9 request back", br_o, 1);
      end else begin
        chk("R12 completion pulse", rsp_valid, 1);
        chk(outcome == 2 ? "R6 R11 error status" : "R5 ok status", rsp_status, exp_status(outcome));
        if (outcome == 1 && !wr) chk("R5 read data", rsp_rdata, rd);
        chk("R1 ready after completion", req_ready, 1);
        @(negedge clk);
        chk("R12 single pulse", rsp_valid, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; arb_int = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_attr = '0; req_wdata = '0;
    bg_i = 1'b0; br_i = 1'b0; bb_i = 1'b0; rdata_i = '0;
    ack = 1'b0; err = 1'b0; rty = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 reset no completion", rsp_valid, 0);
    chk("R4 reset busy low", bb_o, 0);
    chk("R2 reset request low", br_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    chk("R4 no start after reset", start, 0);

    // R11: terminations while not owning the bus are ignored.
    ack = 1'b1; err = 1'b1; rty = 1'b1;
    @(negedge clk);
    ack = 1'b0; err = 1'b0; rty = 1'b0;
    @(negedge clk);
    chk("R11 idle terminations ignored", rsp_valid, 0);
    chk("R11 idle stays ready", req_ready, 1);

    // Directed cases, both arbiter modes.
    run_xfer(0, 0, 32'h0000_1000, 4'h3, 32'h0, 32'hCAFE_0001, 0, 0, 0, 0);
    run_xfer(1, 1, 32'hFFFF_FFFC, 4'hA, 32'h1234_5678, 32'h0, 0, 1, 0, 0);
    run_xfer(0, 1, 32'h0000_2000, 4'h5, 32'hA5A5_A5A5, 32'h0, 2, 0, 1, 0);
    run_xfer(1, 0, 32'h0000_3000, 4'h9, 32'h0, 32'hBEEF_0003, 2, 0, 1, 1);
    run_xfer(1, 1, 32'h0000_4000, 4'h1, 32'h0F0F_0F0F, 32'h0, 1, 1, 0, 1);
    run_xfer(0, 0, 32'h0000_5000, 4'hF, 32'h0, 32'h1111_2222, 1, 1, 1, 1);

    // Random traffic.
    for (int n = 0; n < 60; n++) begin
      run_xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom, 4'($urandom),
               $urandom, $urandom, int'($urandom_range(0, 3)), 1'($urandom_range(0, 3) == 0),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule